// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block sits between a simple memory read port and an instruction consumer. It keeps a code segment and a fetch offset, forms each read address as the segment times sixteen plus the offset, and stores the returned instruction bytes in a small queue. The consumer never touches memory. It takes bytes one per cycle from the queue through a valid/ready handshake.

Refilling runs on its own. While the consumer is busy or stalled, the unit keeps issuing reads until the queue has no room for another read.

The parameter `BUS_BYTES` selects the read width:
- With a 2-byte port, the unit keeps a 6-byte queue.
- With a 1-byte port, it keeps a 4-byte queue.

A flush, raised after a control transfer, empties the queue and loads a new segment and offset. A read still in flight at that moment is allowed to finish on the bus, but its data is dropped.

Top module: `seg_fetch_queue`

## Requirements
- R1: Every read address is `({segment, 4'b0} + offset) mod 2^20`, where segment and offset are the unit's current fetch pointer.
- R2: The consumer receives bytes from successive offsets in the same segment. The offset wraps from 16'hFFFF to 16'h0000 without changing the segment.
- R3: The queue holds at most 6 bytes when `BUS_BYTES` is 2 and at most 4 bytes when `BUS_BYTES` is 1. It never accepts more than that.
- R4: With a 2-byte port, the unit starts a read only when at least two queue slots are free. The returned data is laid out as follows:
  - `mem_rdata_i[7:0]` is the byte at the address with bit 0 cleared.
  - `mem_rdata_i[15:8]` is the byte at that address with bit 0 set.
  - A read from an odd address queues only the upper byte.
  - From an odd start with the consumer stalled, the queue therefore settles at 5 bytes.
- R5: While the consumer is stalled, reads continue until the queue lacks room. After that, `mem_req_o` stays low.
- R6: `byte_valid_o` is low whenever the queue is empty, and it stays low until read data is accepted.
- R7: A flush has the following effects:
  - `byte_valid_o` is low in the cycle after the flush.
  - A handshake in the flush cycle is ignored.
  - Data returned by a read that was pending at the flush is discarded.
  - Fetching restarts at the new segment and offset.
- R8: Once `mem_req_o` is raised, it stays high with `mem_addr_o` unchanged until the cycle in which `mem_ack_i` is high. Data is taken in that cycle, and only one read is outstanding at a time.
- R9: After reset, `byte_valid_o` and `mem_req_o` are low, and fetching begins at `RESET_SEG`:`RESET_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty the queue and load a new fetch pointer |
| flush_seg_i | input | 16 | New code segment, taken with `flush_i` |
| flush_off_i | input | 16 | New fetch offset, taken with `flush_i` |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | 20 | Physical read address |
| mem_ack_i | input | 1 | One-cycle read acknowledge that carries the data |
| mem_rdata_i | input | BUS_BYTES*8 | Read data; lane 0 is the even byte |
| byte_valid_o | output | 1 | Queue head is valid |
| byte_data_o | output | 8 | Queue head byte |
| byte_ready_i | input | 1 | Consumer takes the head byte |

## Verification
The assertions take two things for granted:
- The memory raises `mem_ack_i` only while `mem_req_o` is high, for a single cycle.
- `flush_i` is a single-cycle pulse.

The bench's memory model follows both rules. It acknowledges after a latency of zero to three cycles, drops `mem_ack_i` after one cycle, and can be held silent to freeze refills. The bench pulses flush for exactly one cycle and keeps the consumer's ready low during it.

Both bus widths run side by side under the same sweep of start pointers, latencies and consumer patterns. The sweep includes odd starts, offsets that wrap at 16 bits, and segment-plus-offset sums that wrap at 20 bits.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int SEG_W = 16;
  localparam int OFF_W = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W = 20;

  // queue size tied to the read width
  function automatic int queue_depth(input int bus_bytes);
    return (bus_bytes == 2) ? 6 : 4;
  endfunction
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam int BASE_W = SEG_W + SHIFT;
  localparam int SUM_W = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'({seg_i, {SHIFT{1'b0}}}) + SUM_W'(off_i);
  assign pa_o = sum[PA_W-1:0];
endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
  parameter int DEPTH = 6,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic [$clog2(LANES+1)-1:0]  wr_cnt_i,
  input  logic [LANES*8-1:0]          wr_data_i,
  input  logic                        pop_i,
  output logic                        rd_valid_o,
  output logic [7:0]                  rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]  count_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  // storage: no reset, so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (!clr_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (int'(wr_cnt_i) > l) mem_q[ptr_add(wr_ptr_q, l)] <= wr_data_i[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= ptr_add(wr_ptr_q, int'(wr_cnt_i));
      if (pop_i) rd_ptr_q <= ptr_add(rd_ptr_q, 1);
      count_q <= count_q + CW'(wr_cnt_i) - CW'(pop_i);
    end
  end

  assign rd_valid_o = (count_q != '0);
  assign rd_data_o  = mem_q[rd_ptr_q];
  assign count_o    = count_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count_q) + int'(wr_cnt_i) - int'(pop_i)) <= DEPTH);
endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl #(
  parameter int BUS_BYTES = 2,
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W = 20,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush_i,
  input  logic [SEG_W-1:0]                flush_seg_i,
  input  logic [OFF_W-1:0]                flush_off_i,
  input  logic [PA_W-1:0]                 pa_i,
  output logic [SEG_W-1:0]                seg_o,
  output logic [OFF_W-1:0]                off_o,
  input  logic [$clog2(DEPTH+1)-1:0]      q_count_i,
  output logic                            mem_req_o,
  output logic [PA_W-1:0]                 mem_addr_o,
  input  logic                            mem_ack_i,
  input  logic [BUS_BYTES*8-1:0]          mem_rdata_i,
  output logic [$clog2(BUS_BYTES+1)-1:0]  wr_cnt_o,
  output logic [BUS_BYTES*8-1:0]          wr_data_o
);
  localparam int NW = $clog2(BUS_BYTES+1);

  logic              busy_q, drop_q;
  logic [PA_W-1:0]   addr_q;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [NW-1:0]     take_n;
  logic [BUS_BYTES*8-1:0] take_data;
  logic              land, keep, room, issue;

  generate
    if (BUS_BYTES == 2) begin : g_word
      always_comb begin
        if (addr_q[0]) begin
          take_n    = NW'(1);
          take_data = {8'h00, mem_rdata_i[15:8]};
        end else begin
          take_n    = NW'(2);
          take_data = mem_rdata_i;
        end
      end
    end else begin : g_byte
      always_comb begin
        take_n    = NW'(1);
        take_data = mem_rdata_i;
      end
    end
  endgenerate

  assign land  = busy_q && mem_ack_i;
  assign keep  = land && !drop_q && !flush_i;
  assign room  = (DEPTH - int'(q_count_i)) >= BUS_BYTES;
  assign issue = !busy_q && !flush_i && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
      seg_q  <= RESET_SEG;
      off_q  <= RESET_OFF;
    end else if (flush_i) begin
      seg_q  <= flush_seg_i;
      off_q  <= flush_off_i;
      busy_q <= busy_q && !mem_ack_i;
      drop_q <= busy_q && !mem_ack_i;
    end else if (land) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      if (!drop_q) off_q <= off_q + OFF_W'(take_n);
    end else if (issue) begin
      busy_q <= 1'b1;
      addr_q <= pa_i;
    end
  end

  assign seg_o      = seg_q;
  assign off_o      = off_q;
  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign wr_cnt_o   = keep ? take_n : '0;
  assign wr_data_o  = take_data;

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !mem_ack_i) |=> (busy_q && $stable(mem_addr_o)));

  // R4
  issue_room_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ((DEPTH - int'($past(q_count_i))) >= BUS_BYTES));
endmodule

// File: rtl/seg_fetch_queue.sv
module seg_fetch_queue
  import pf_pkg::*;
#(
  parameter int BUS_BYTES = 2,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush_i,
  input  logic [SEG_W-1:0]        flush_seg_i,
  input  logic [OFF_W-1:0]        flush_off_i,
  output logic                    mem_req_o,
  output logic [PA_W-1:0]         mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [BUS_BYTES*8-1:0]  mem_rdata_i,
  output logic                    byte_valid_o,
  output logic [7:0]              byte_data_o,
  input  logic                    byte_ready_i
);
  localparam int DEPTH = queue_depth(BUS_BYTES);
  localparam int CW = $clog2(DEPTH+1);
  localparam int NW = $clog2(BUS_BYTES+1);

  logic [SEG_W-1:0]       cur_seg;
  logic [OFF_W-1:0]       cur_off;
  logic [PA_W-1:0]        cur_pa;
  logic [CW-1:0]          q_count;
  logic [NW-1:0]          wr_cnt;
  logic [BUS_BYTES*8-1:0] wr_data;
  logic                   pop;

  pf_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SEG_SHIFT), .PA_W(PA_W)
  ) u_addr (
    .seg_i(cur_seg), .off_i(cur_off), .pa_o(cur_pa)
  );

  pf_fetch_ctrl #(
    .BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH), .SEG_W(SEG_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .flush_seg_i(flush_seg_i), .flush_off_i(flush_off_i),
    .pa_i(cur_pa), .seg_o(cur_seg), .off_o(cur_off),
    .q_count_i(q_count),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .wr_cnt_o(wr_cnt), .wr_data_o(wr_data)
  );

  pf_byte_queue #(
    .DEPTH(DEPTH), .LANES(BUS_BYTES)
  ) u_queue (
    .clk(clk), .rst(rst), .clr_i(flush_i),
    .wr_cnt_i(wr_cnt), .wr_data_i(wr_data), .pop_i(pop),
    .rd_valid_o(byte_valid_o), .rd_data_o(byte_data_o), .count_o(q_count)
  );

  assign pop = byte_valid_o && byte_ready_i && !flush_i;

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !byte_valid_o);

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid_o && !mem_ack_i) |=> !byte_valid_o);
endmodule

// File: tb/seg_fetch_queue_tb_top.sv
module seg_fetch_queue_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, flush, ready;
  logic [15:0] fseg, foff;
  logic        req [2];
  logic        ack [2];
  logic        valid [2];
  logic [19:0] addr [2];
  logic [7:0]  bdata [2];
  logic [15:0] rdata [2];

  seg_fetch_queue #(.BUS_BYTES(2)) dut_i (
    .clk(clk), .rst(rst), .flush_i(flush), .flush_seg_i(fseg), .flush_off_i(foff),
    .mem_req_o(req[0]), .mem_addr_o(addr[0]), .mem_ack_i(ack[0]),
    .mem_rdata_i(rdata[0]), .byte_valid_o(valid[0]), .byte_data_o(bdata[0]),
    .byte_ready_i(ready)
  );

  seg_fetch_queue #(.BUS_BYTES(1)) dut8_i (
    .clk(clk), .rst(rst), .flush_i(flush), .flush_seg_i(fseg), .flush_off_i(foff),
    .mem_req_o(req[1]), .mem_addr_o(addr[1]), .mem_ack_i(ack[1]),
    .mem_rdata_i(rdata[1][7:0]), .byte_valid_o(valid[1]), .byte_data_o(bdata[1]),
    .byte_ready_i(ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  int lat_mode = 0, ready_mode = 0;
  bit hold = 0, chk_empty = 0;
  logic [15:0] eseg;
  logic [15:0] eoff [2];
  int got [2];
  int lat [2];
  bit prev_pend [2];
  logic [19:0] prev_addr [2];

  function automatic logic [7:0] fb(input logic [19:0] p);
    return p[7:0] ^ {p[11:8], p[15:12]} ^ {p[19:16], 4'hA};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int next_lat();
    case (lat_mode)
      0: return 0;
      1: return cyc % 3;
      default: return 3;
    endcase
  endfunction

  function automatic bit pick_ready();
    case (ready_mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return (cyc % 3) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input bit do_flush, input logic [15:0] s, input logic [15:0] o);
    @(negedge clk);
    cyc++;
    for (int k = 0; k < 2; k++) begin
      bit was_ack;
      was_ack = ack[k];
      // R8: address held while the read waits
      if (req[k] && prev_pend[k])
        chk(addr[k] == prev_addr[k], "R8 address held", addr[k], prev_addr[k]);
      ack[k] = 1'b0;
      if (!was_ack && req[k] && !hold) begin
        if (lat[k] == 0) begin
          ack[k] = 1'b1;
          if (k == 0) rdata[k] = {fb({addr[k][19:1], 1'b1}), fb({addr[k][19:1], 1'b0})};
          else        rdata[k] = {8'h00, fb(addr[k])};
          lat[k] = next_lat();
        end else begin
          lat[k] = lat[k] - 1;
        end
      end
      prev_pend[k] = req[k] && !ack[k];
      prev_addr[k] = addr[k];
    end
    if (do_flush) begin
      flush = 1'b1; fseg = s; foff = o; ready = 1'b0;
    end else begin
      flush = 1'b0; ready = pick_ready();
    end
    for (int k = 0; k < 2; k++) begin
      if (!do_flush && chk_empty)
        chk(!valid[k], "R7 queue empty after flush", valid[k], 0);
      if (!do_flush && ready && valid[k]) begin
        chk(bdata[k] == fb(phys(eseg, eoff[k])), "R1 R2 byte stream",
            bdata[k], fb(phys(eseg, eoff[k])));
        eoff[k] = eoff[k] + 16'd1;
        got[k]++;
      end
    end
    chk_empty = do_flush;
    if (do_flush) begin
      eseg = s;
      for (int k = 0; k < 2; k++) begin
        eoff[k] = o; got[k] = 0;
      end
    end
  endtask

  task automatic run_until(input int n);
    int guard;
    guard = 0;
    while ((got[0] < n || got[1] < n) && guard < 3000) begin
      step(1'b0, 16'h0, 16'h0);
      guard++;
    end
    chk(guard < 3000, "R2 stream progress", guard, 3000);
  endtask

  task automatic fill_drain(input logic [15:0] o, input int exp0);
    lat_mode = 0; ready_mode = 3; hold = 0;
    step(1'b1, 16'h2000, o);
    repeat (40) step(1'b0, 16'h0, 16'h0);
    // R5: queue full, no read pending
    chk(req[0] == 1'b0, "R5 refill stops when full (2-byte)", req[0], 0);
    chk(req[1] == 1'b0, "R5 refill stops when full (1-byte)", req[1], 0);
    hold = 1; ready_mode = 0;
    repeat (20) step(1'b0, 16'h0, 16'h0);
    // R3 / R4: bytes held by a stalled queue
    chk(got[0] == exp0, "R3 R4 2-byte queue fill", got[0], exp0);
    chk(got[1] == 4, "R3 1-byte queue fill", got[1], 4);
    // R6: empty queue keeps valid low
    chk(!valid[0], "R6 valid low when empty", valid[0], 0);
    chk(!valid[1], "R6 valid low when empty", valid[1], 0);
    // release the held read, then flush: its data must be dropped (R7)
    hold = 0;
    step(1'b1, 16'h3A5C, 16'h0007);
    run_until(10);
  endtask

  logic [15:0] cfg_seg [6];
  logic [15:0] cfg_off [6];

  initial begin
    cfg_seg[0] = 16'h1234; cfg_off[0] = 16'h0000;
    cfg_seg[1] = 16'h1234; cfg_off[1] = 16'hFFFD;
    cfg_seg[2] = 16'hFFFF; cfg_off[2] = 16'hFFF8;
    cfg_seg[3] = 16'h0000; cfg_off[3] = 16'h0001;
    cfg_seg[4] = 16'hF000; cfg_off[4] = 16'hFFFF;
    cfg_seg[5] = 16'h8001; cfg_off[5] = 16'h7FFE;
    rst = 1'b1; flush = 1'b0; ready = 1'b0; fseg = '0; foff = '0;
    for (int k = 0; k < 2; k++) begin
      ack[k] = 1'b0; rdata[k] = '0; got[k] = 0; lat[k] = 0;
      prev_pend[k] = 1'b0; prev_addr[k] = '0; eoff[k] = 16'h0000;
    end
    eseg = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!valid[0] && !valid[1], "R9 valid low in reset", {valid[0], valid[1]}, 0);
    chk(!req[0] && !req[1], "R9 no request in reset", {req[0], req[1]}, 0);
    rst = 1'b0;
    // R9: first bytes come from the reset pointer
    run_until(8);
    for (int i = 0; i < 6; i++) begin
      for (int lm = 0; lm < 3; lm++) begin
        for (int rm = 0; rm < 3; rm++) begin
          lat_mode = lm; ready_mode = rm;
          step(1'b1, cfg_seg[i], cfg_off[i]);
          run_until(12);
        end
      end
    end
    fill_drain(16'h0100, 6);
    fill_drain(16'h0101, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule